// File: doc/BRIEF.md
# Paired Run-Length Sample Encoder

This block sits between the sample capture path of a logic analyzer and its capture memory. It compresses runs of repeated sample values. Each run is sent out as two words: a data word that holds the value, then a count word. A reader of the memory can therefore parse the stream as strict pairs without any knowledge of how the encoder works inside. The configured sample width is 8, 16, 24 or 32 bits. The count field is as wide as the sample for 8 and 16 bits, and 32 bits wide for the two larger widths.

In the normal mode the encoder keeps one open run and extends it while equal samples arrive. When a different value arrives, or when the count saturates, it emits the open run as a pair. A stop command flushes the open run as a last pair. In demultiplexed mode each input beat carries two half-width samples. Each half is emitted as a pair of its own with a zero count. Inside the block, a run of a single sample is held as a one-bit marker and not as a stored count, and the output stage expands that marker into a zero count word.

The state machine has eight states:
- S_IDLE: no open run.
- S_RUN: a run is open and growing.
- S_PAIR_D and S_PAIR_C: the value, then the count, of a closed run.
- S_DLO_D, S_DLO_C, S_DHI_D and S_DHI_C: the lower half and then the upper half of a demultiplexed beat.

The transitions are:
- S_IDLE to S_RUN when a sample is accepted in normal mode.
- S_IDLE to S_DLO_D when a beat is accepted in demultiplexed mode.
- S_RUN to S_PAIR_D when the value changes, when the count saturates, or when a stop is seen.
- S_PAIR_D to S_PAIR_C on each accepted output word.
- S_PAIR_C back to S_RUN after a change or saturation, and to S_IDLE after a stop.
- Through the four demultiplexed states in order, then back to S_IDLE.

Top module: `rle_pair_encoder`

## Requirements
- R1: After reset the accepted output words alternate strictly: a data word (out_is_count=0), then a count word (out_is_count=1), starting with a data word.
- R2: cfg_width selects the sample width: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. Input bits above the selected width are ignored when samples are compared, and they read as zero in data words.
- R3: The count field is 8 bits wide for cfg_width 0, 16 bits for cfg_width 1, and 32 bits for cfg_width 2 and 3. The largest counts are 255, 65535 and 4294967295.
- R4: Consecutive equal samples form one run. Its count word gives the number of samples after the first one, so a run of N samples carries the count N-1.
- R5: When the open run holds the largest count and another equal sample arrives, the encoder emits the pair with the largest count. The new sample then opens a new run of the same value with count 0.
- R6: A run of a single sample produces a count word of zero.
- R7: With cfg_demux=1, each accepted beat carries two samples of half the selected width: the low half in the bits below the half width, and the high half in the next half width of bits. The beat produces the pair (low half, 0) followed by the pair (high half, 0). No run merging takes place.
- R8: A one-cycle stop pulse emits the open run as its final pair and returns the encoder to S_IDLE. A stop with no open run emits nothing. After a flush, the next sample opens a new run.
- R9: out_valid, out_data and out_is_count stay stable while out_ready is low. in_ready is never high while out_valid is high, and it is low in S_RUN while a stop is in effect.
- R10: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 2 | Sample width select (0..3 gives 8/16/24/32 bits) |
| cfg_demux | input | 1 | Each beat carries two half-width samples |
| stop | input | 1 | One-cycle pulse that ends encoding and flushes the open run |
| in_valid | input | 1 | Sample present |
| in_data | input | DATA_W | Sample word |
| in_ready | output | 1 | Sample taken on this edge when in_valid is high |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Data value or run count |
| out_is_count | output | 1 | 1 when out_data is a count word |

## Verification
The assertions assume that cfg_width and cfg_demux change only while the encoder is in S_IDLE with nothing pending. Under that assumption the width and zero-count checks on the output words are valid. The stimulus meets this assumption: it changes configuration only after a stop and a long drain, and it starts each demultiplexed sweep from S_IDLE. Stop pulses are issued while in_valid is low, so the point at which a flush occurs relative to the sample stream is defined by the sequence of accepted samples and not by a race between the two inputs.

// File: rtl/rle_pair_pkg.sv
package rle_pair_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RUN    = 3'd1,
        S_PAIR_D = 3'd2,
        S_PAIR_C = 3'd3,
        S_DLO_D  = 3'd4,
        S_DLO_C  = 3'd5,
        S_DHI_D  = 3'd6,
        S_DHI_C  = 3'd7
    } enc_state_t;

endpackage

// File: rtl/rle_width_decode.sv
module rle_width_decode #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]              sel,
    output logic [DATA_W-1:0]       data_mask,
    output logic [DATA_W-1:0]       cnt_max,
    output logic [DATA_W-1:0]       half_mask,
    output logic [$clog2(DATA_W):0] half_shift
);
    localparam int BW = $clog2(DATA_W) + 1;
    localparam int Q  = DATA_W / 4;
    localparam logic [BW-1:0] W1 = BW'(Q);
    localparam logic [BW-1:0] W2 = BW'(2 * Q);
    localparam logic [BW-1:0] W3 = BW'(3 * Q);
    localparam logic [BW-1:0] W4 = BW'(DATA_W);

    logic [BW-1:0] w_bits;
    logic [BW-1:0] c_bits;

    always_comb begin
        unique case (sel)
            2'd0:    begin w_bits = W1; c_bits = W1; end
            2'd1:    begin w_bits = W2; c_bits = W2; end
            2'd2:    begin w_bits = W3; c_bits = W4; end
            default: begin w_bits = W4; c_bits = W4; end
        endcase
        half_shift = w_bits >> 1;
        for (int i = 0; i < DATA_W; i++) begin
            data_mask[i] = (BW'(i) < w_bits);
            cnt_max[i]   = (BW'(i) < c_bits);
            half_mask[i] = (BW'(i) < half_shift);
        end
    end

endmodule

// File: rtl/rle_run_track.sv
module rle_run_track #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              incr,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] cnt_max,
    output logic [DATA_W-1:0] run_val,
    output logic [DATA_W-1:0] run_cnt,
    output logic              same,
    output logic              at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_val <= '0;
            run_cnt <= '0;
        end else if (load) begin
            run_val <= d;
            run_cnt <= '0;
        end else if (incr) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign same   = (d == run_val);
    assign at_max = (run_cnt == cnt_max);

endmodule

// File: rtl/rle_pair_fmt.sv
module rle_pair_fmt
    import rle_pair_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  enc_state_t        state,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [DATA_W-1:0] hold_cnt,
    input  logic              hold_single,
    input  logic [DATA_W-1:0] dmx_lo,
    input  logic [DATA_W-1:0] dmx_hi,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_count
);
    always_comb begin
        out_valid    = 1'b1;
        out_is_count = 1'b0;
        out_data     = '0;
        unique case (state)
            S_IDLE, S_RUN: out_valid = 1'b0;
            S_PAIR_D: out_data = hold_data;
            S_PAIR_C: begin
                out_is_count = 1'b1;
                out_data     = hold_single ? '0 : hold_cnt;
            end
            S_DLO_D: out_data = dmx_lo;
            S_DHI_D: out_data = dmx_hi;
            S_DLO_C, S_DHI_C: out_is_count = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/rle_pair_encoder.sv
module rle_pair_encoder
    import rle_pair_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_demux,
    input  logic              stop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_count
);
    localparam int SW = $clog2(DATA_W) + 1;

    enc_state_t state, nxt;
    logic ret_run, nxt_ret;
    logic stop_pend, nxt_pend;

    logic [DATA_W-1:0] data_mask, cnt_max, half_mask;
    logic [SW-1:0]     half_shift;
    logic [DATA_W-1:0] d_masked;
    logic [DATA_W-1:0] run_val, run_cnt;
    logic              same, at_max;
    logic              run_load, run_inc, cap_hold, cap_dmx, stop_now;

    logic [DATA_W-1:0] hold_data, hold_cnt, dmx_lo, dmx_hi;
    logic              hold_single;

    rle_width_decode #(.DATA_W(DATA_W)) u_wdec (
        .sel        (cfg_width),
        .data_mask  (data_mask),
        .cnt_max    (cnt_max),
        .half_mask  (half_mask),
        .half_shift (half_shift)
    );

    assign d_masked = in_data & data_mask;

    rle_run_track #(.DATA_W(DATA_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (run_load),
        .incr    (run_inc),
        .d       (d_masked),
        .cnt_max (cnt_max),
        .run_val (run_val),
        .run_cnt (run_cnt),
        .same    (same),
        .at_max  (at_max)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            ret_run   <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            state     <= nxt;
            ret_run   <= nxt_ret;
            stop_pend <= nxt_pend;
        end
    end

    // Held pair and demultiplexed halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data   <= '0;
            hold_cnt    <= '0;
            hold_single <= 1'b1;
            dmx_lo      <= '0;
            dmx_hi      <= '0;
        end else begin
            if (cap_hold) begin
                hold_data   <= run_val;
                hold_single <= (run_cnt == '0);
                if (run_cnt != '0) hold_cnt <= run_cnt;
            end
            if (cap_dmx) begin
                dmx_lo <= in_data & half_mask;
                dmx_hi <= (in_data >> half_shift) & half_mask;
            end
        end
    end

    // Next state and control outputs
    always_comb begin
        nxt      = state;
        nxt_ret  = ret_run;
        nxt_pend = stop_pend;
        in_ready = 1'b0;
        run_load = 1'b0;
        run_inc  = 1'b0;
        cap_hold = 1'b0;
        cap_dmx  = 1'b0;
        stop_now = stop | stop_pend;
        unique case (state)
            S_IDLE: begin
                in_ready = 1'b1;
                nxt_pend = 1'b0;
                if (in_valid) begin
                    if (cfg_demux) begin
                        cap_dmx = 1'b1;
                        nxt     = S_DLO_D;
                    end else begin
                        run_load = 1'b1;
                        nxt      = S_RUN;
                    end
                end
            end
            S_RUN: begin
                in_ready = !stop_now;
                if (stop_now) begin
                    cap_hold = 1'b1;
                    nxt_ret  = 1'b0;
                    nxt_pend = 1'b0;
                    nxt      = S_PAIR_D;
                end else if (in_valid) begin
                    if (same && !at_max) begin
                        run_inc = 1'b1;
                    end else begin
                        cap_hold = 1'b1;
                        run_load = 1'b1;
                        nxt_ret  = 1'b1;
                        nxt      = S_PAIR_D;
                    end
                end
            end
            S_PAIR_D: begin
                if (stop) nxt_pend = 1'b1;
                if (out_ready) nxt = S_PAIR_C;
            end
            S_PAIR_C: begin
                if (stop) nxt_pend = 1'b1;
                if (out_ready) nxt = ret_run ? S_RUN : S_IDLE;
            end
            S_DLO_D: if (out_ready) nxt = S_DLO_C;
            S_DLO_C: if (out_ready) nxt = S_DHI_D;
            S_DHI_D: if (out_ready) nxt = S_DHI_C;
            S_DHI_C: if (out_ready) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    rle_pair_fmt #(.DATA_W(DATA_W)) u_fmt (
        .state        (state),
        .hold_data    (hold_data),
        .hold_cnt     (hold_cnt),
        .hold_single  (hold_single),
        .dmx_lo       (dmx_lo),
        .dmx_hi       (dmx_hi),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_is_count (out_is_count)
    );

endmodule

// File: rtl/rle_pair_encoder_chk.sv
module rle_pair_encoder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_width,
    input logic              cfg_demux,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_is_count
);
    localparam int Q = DATA_W / 4;

    logic exp_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      exp_cnt <= 1'b0;
        else if (out_valid && out_ready) exp_cnt <= ~exp_cnt;
    end

    assert_pair_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_is_count == exp_cnt));

    assert_data_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_count && cfg_width == 2'd0) |-> ((out_data >> Q) == '0));

    assert_count_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_count && cfg_width == 2'd1) |-> ((out_data >> (2 * Q)) == '0));

    assert_demux_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_count && cfg_demux) |-> (out_data == '0));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_count)));

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

endmodule

bind rle_pair_encoder rle_pair_encoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_width    (cfg_width),
    .cfg_demux    (cfg_demux),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_is_count (out_is_count)
);

// File: tb/sim_rle_pair_encoder.sv
module sim_rle_pair_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_demux = 1'b0;
    logic        stop = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_is_count;

    always #4 clk = ~clk;

    rle_pair_encoder #(.DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_demux(cfg_demux),
        .stop(stop), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_is_count(out_is_count)
    );

    int errors = 0;
    int checks = 0;
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    bit          gotc_q[$];
    bit          expc_q[$];
    bit          throttle = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          overlap_viol = 0;
    int          stable_viol = 0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    // reference model state
    bit          m_have = 1'b0;
    logic [31:0] m_cur = '0;
    logic [31:0] m_cnt = '0;

    function automatic logic [31:0] wmask(int k);
        return (k == 3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (k + 1))) - 32'd1);
    endfunction

    function automatic logic [31:0] cmax(int k);
        return (k == 0) ? 32'd255 : (k == 1) ? 32'd65535 : 32'hFFFF_FFFF;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_pair(logic [31:0] v, logic [31:0] c);
        exp_q.push_back(v); expc_q.push_back(1'b0);
        exp_q.push_back(c); expc_q.push_back(1'b1);
    endtask

    task automatic m_sample(logic [31:0] d);
        logic [31:0] m;
        m = d & wmask(int'(cfg_width));
        if (m_have && m == m_cur && m_cnt != cmax(int'(cfg_width))) begin
            m_cnt = m_cnt + 1;
        end else begin
            if (m_have) m_pair(m_cur, m_cnt);
            m_have = 1'b1; m_cur = m; m_cnt = '0;
        end
    endtask

    task automatic m_flush();
        if (m_have) m_pair(m_cur, m_cnt);
        m_have = 1'b0;
    endtask

    // output monitor: out_ready changes at the falling edge, sampling 2 ns later
    always begin
        @(negedge clk);
        out_ready = throttle ? lfsr[0] : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #2;
        if (rst_n) begin
            if (in_ready && out_valid) overlap_viol++;
            if (prev_stall && (!out_valid || out_data != prev_data)) stable_viol++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                gotc_q.push_back(out_is_count);
            end
        end
    end

    // called at a falling edge, returns at a falling edge
    task automatic send(logic [31:0] d);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (cfg_demux) begin
            logic [31:0] hm;
            int h;
            h  = 4 * (int'(cfg_width) + 1);
            hm = (32'd1 << h) - 32'd1;
            m_pair(d & hm, 32'd0);
            m_pair((d >> h) & hm, 32'd0);
        end else begin
            m_sample(d);
        end
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        m_flush();
    endtask

    task automatic drain();
        repeat (60) @(negedge clk);
    endtask

    task automatic compare(string req);
        check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
            check(gotc_q[i] == expc_q[i], "R1 word order", 32'(gotc_q[i]), 32'(expc_q[i]));
        end
        got_q.delete(); gotc_q.delete(); exp_q.delete(); expc_q.delete();
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R10 in_ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'd1);

        // R4 R6 R2: run-length sweep over every width, garbage above the width
        throttle = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_width = 2'(k);
            for (int len = 1; len <= 6; len++) begin
                for (int r = 0; r < len; r++) begin
                    logic [31:0] g;
                    g = 32'(r * 7 + len) << (8 * (k + 1));
                    send((32'h5A3C_96E1 + 32'(len * 17)) | (k == 3 ? 32'd0 : g));
                end
            end
            do_stop();
            drain();
            compare("R4 R6 R2 run sweep");
        end

        // R5 R3: saturation in 8-bit width, none in 16-bit width
        cfg_width = 2'd0;
        for (int i = 0; i < 300; i++) send(32'h0000_003C);
        send(32'h0000_003D);
        do_stop(); drain();
        compare("R5 saturation at 255");
        for (int i = 0; i < 256; i++) send(32'h0000_0077);
        do_stop(); drain();
        compare("R5 exactly 256 samples");
        cfg_width = 2'd1;
        for (int i = 0; i < 300; i++) send(32'hFFFF_1234);
        do_stop(); drain();
        compare("R3 16-bit count field");

        // R7: demultiplexed beats for every width
        cfg_demux = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_width = 2'(k);
            send(32'hC3A5_5AF0);
            send(32'hC3A5_5AF0);
            send(32'h1234_9876 + 32'(k));
            drain();
            compare("R7 demux halves");
        end
        cfg_demux = 1'b0;

        // R8: stop with nothing open, then new run after a flush
        cfg_width = 2'd2;
        do_stop(); drain();
        check(got_q.size() == 0, "R8 idle stop emits nothing", got_q.size(), 0);
        compare("R8 idle stop");
        send(32'h00AB_CDEF); send(32'h00AB_CDEF);
        do_stop();
        send(32'h00AB_CDEF);
        do_stop(); drain();
        compare("R8 flush then restart");

        check(overlap_viol == 0, "R9 in_ready with out_valid", overlap_viol, 0);
        check(stable_viol == 0, "R9 output stable while stalled", stable_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule